// File: doc/BRIEF.md
# Device Configuration Register Space

This block holds the 256-byte configuration register space of one device function. A host reaches it through a single-cycle request port. Each request carries a 24-bit configuration address, a length of 1, 2 or 4 bytes, and for writes a data word. The block answers a request only when the bus and device/function fields of the address match its own parameterised location. Read data comes back one cycle after the request, little-endian, on a registered response.

Every byte of the space has its own write-enable mask. The mask is fixed at elaboration from the field layout: identity, class and type fields are read-only, the command register exposes only three enable bits, and each base address register exposes only the address bits above its decoded size. A write merges its data into the stored bytes through these masks. When a write alters a base address register or one of the two decode-enable bits of the command register, the block emits a one-cycle remap pulse. A downstream address decoder uses that pulse to rebuild its windows.

Top module: `devcfg_space`

## Requirements
- R1: A request hits only when address bits 23:16 equal BUS_SEL and bits 15:8 equal DEVFN_SEL. A write that misses changes nothing, and a read that misses returns 0xFFFFFFFF.
- R2: Read data is little-endian: the byte at the register offset (address bits 7:0) appears in bits 7:0 and higher offsets appear in higher bytes. Unused upper bytes of 1- and 2-byte reads are zero.
- R3: A 4-byte read is served only at offsets 0x00–0xFC and a 2-byte read only at 0x00–0xFE. A 1-byte read is served at any offset. Any other read, including one with a length other than 1, 2 or 4, returns 0xFFFFFFFF.
- R4: rsp_valid is high in exactly the cycle after a read request, with rsp_rdata valid in that cycle. It stays low after writes.
- R5: A write of length 1, 2 or 4 updates byte offset+i with the data byte i (least significant first) as (old & ~mask) | (data & mask). Bytes past offset 0xFF are dropped. A write of any other length is ignored.
- R6: Bytes 0x00–0x01 read VENDOR_ID and bytes 0x02–0x03 read DEVICE_ID, low byte first. These bytes and all other header bytes that have no writable field (for example 0x08) never change.
- R7: In the command byte at offset 0x04, only bit 0 (I/O decode), bit 1 (memory decode) and bit 2 (bus mastering) are writable. Byte 0x05 is read-only.
- R8: Bytes 0x0C and 0x3C, and every byte from 0x40 to 0xFF, are fully writable.
- R9: Base address register n sits at offset 0x10+4n. Its writable bits are ~(size-1), bit 0 reads 1 for an I/O register and 0 for a memory register, and a register of size 0 reads all zero. The expansion ROM register at 0x30 has writable bits ~(size-1) plus its enable bit 0.
- R10: remap_evt pulses for one cycle, in the cycle after a write, only when that write changed a byte in 0x10–0x27 or command bit 0 or 1. A write that leaves those bits unchanged, or that changes only other bits, gives no pulse.
- R11: After reset, rsp_valid and remap_evt are low and every writable byte holds its reset value (zero, except the type bit of I/O base registers).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Bus [23:16], device/function [15:8], register offset [7:0] |
| req_len | input | 3 | Access length in bytes (1, 2 or 4) |
| req_wdata | input | 32 | Write data, least significant byte first |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 32 | Read response data |
| remap_evt | output | 1 | One-cycle pulse after a decode-relevant change |

## Verification
The assertions take for granted that each request lasts exactly one cycle and is never stalled. They also take for granted that req_write and req_len are settled whenever req_valid is high. Under those conditions, a read always yields a response one cycle later, and storage moves only after a write. The stimulus drives one request at a time, away from the clock edge, with an idle cycle between requests. Lengths outside 1, 2 and 4 are sent on purpose to cover the rejection paths.

// File: rtl/devcfg_pkg.sv
package devcfg_pkg;

   localparam int CFG_BYTES = 256;
   localparam int NUM_BARS  = 6;

   localparam int OFS_CMD     = 8'h04;
   localparam int OFS_CLSZ    = 8'h0C;
   localparam int OFS_BAR_LO  = 8'h10;
   localparam int OFS_BAR_END = OFS_BAR_LO + 4 * NUM_BARS;
   localparam int OFS_ROM     = 8'h30;
   localparam int OFS_IRQLINE = 8'h3C;
   localparam int OFS_OPEN    = 8'h40;

   localparam logic [7:0] CMD_WMASK = 8'h07;

   typedef logic [NUM_BARS-1:0][31:0] bar_size_t;
   typedef logic [CFG_BYTES-1:0][7:0] cfg_arr_t;

   // Writable bits of one byte, from the field it belongs to.
   function automatic logic [7:0] byte_mask(input int idx, input bar_size_t sz,
                                            input logic [31:0] rom);
      logic [31:0] w;
      int          n;
      w = '0;
      if (idx >= OFS_OPEN || idx == OFS_CLSZ || idx == OFS_IRQLINE) begin
         w = 32'hFFFF_FFFF;
      end else if (idx == OFS_CMD) begin
         w = {24'd0, CMD_WMASK};
      end else if (idx >= OFS_BAR_LO && idx < OFS_BAR_END) begin
         n = (idx - OFS_BAR_LO) / 4;
         if (sz[n] != 32'd0) w = ~(sz[n] - 32'd1);
      end else if (idx >= OFS_ROM && idx < OFS_ROM + 4) begin
         if (rom != 32'd0) w = ~(rom - 32'd1) | 32'd1;
      end
      return w[(idx % 4) * 8 +: 8];
   endfunction

   // Reset content of one byte.
   function automatic logic [7:0] byte_reset(input int idx, input logic [15:0] ven,
                                             input logic [15:0] dev, input bar_size_t sz,
                                             input logic [NUM_BARS-1:0] io);
      int n;
      case (idx)
         0: return ven[7:0];
         1: return ven[15:8];
         2: return dev[7:0];
         3: return dev[15:8];
         default: begin
            if (idx >= OFS_BAR_LO && idx < OFS_BAR_END && (idx % 4) == 0) begin
               n = (idx - OFS_BAR_LO) / 4;
               if (sz[n] != 32'd0 && io[n]) return 8'h01;
            end
            return 8'h00;
         end
      endcase
   endfunction

endpackage

// File: rtl/devcfg_decode.sv
module devcfg_decode #(
   parameter logic [7:0] BUS_SEL   = 8'h00,
   parameter logic [7:0] DEVFN_SEL = 8'h18
) (
   input  logic        req_valid,
   input  logic        req_write,
   input  logic [23:0] req_addr,
   input  logic [2:0]  req_len,
   output logic        hit,
   output logic [7:0]  offset,
   output logic        wr_en,
   output logic        rd_en,
   output logic        rd_ok
);
   logic len_legal;

   always_comb begin
      hit       = (req_addr[23:16] == BUS_SEL) && (req_addr[15:8] == DEVFN_SEL);
      offset    = req_addr[7:0];
      len_legal = (req_len == 3'd1) || (req_len == 3'd2) || (req_len == 3'd4);
      wr_en     = req_valid && req_write && hit && len_legal;
      rd_en     = req_valid && !req_write;
      rd_ok     = hit && ((req_len == 3'd1) ||
                          (req_len == 3'd2 && offset <= 8'hFE) ||
                          (req_len == 3'd4 && offset <= 8'hFC));
   end
endmodule

// File: rtl/devcfg_store.sv
module devcfg_store
   import devcfg_pkg::*;
#(
   parameter logic [15:0]         VENDOR_ID = 16'hABCD,
   parameter logic [15:0]         DEVICE_ID = 16'h1234,
   parameter bar_size_t           BAR_SIZE  = '0,
   parameter logic [NUM_BARS-1:0] BAR_IS_IO = '0,
   parameter logic [31:0]         ROM_SIZE  = 32'd0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [7:0]  wr_off,
   input  logic [2:0]  wr_len,
   input  logic [31:0] wr_data,
   output cfg_arr_t    cfg_q,
   output logic        remap_q
);
   cfg_arr_t cfg_d;
   logic     chg;

   for (genvar b = 0; b < CFG_BYTES; b++) begin : g_byte
      localparam logic [7:0] MASK = byte_mask(b, BAR_SIZE, ROM_SIZE);
      localparam logic [7:0] RSTV = byte_reset(b, VENDOR_ID, DEVICE_ID, BAR_SIZE, BAR_IS_IO);
      localparam logic [7:0] BIDX = 8'(b);
      if (MASK == 8'h00) begin : g_const
         assign cfg_q[b] = RSTV;
         assign cfg_d[b] = RSTV;
      end else begin : g_reg
         logic [7:0] lane;
         logic       sel;
         logic [7:0] din;
         logic [7:0] nxt;
         logic [7:0] q_r;
         always_comb begin
            lane = BIDX - wr_off;
            sel  = wr_en && (BIDX >= wr_off) && (lane < {5'd0, wr_len});
            case (lane[1:0])
               2'd0:    din = wr_data[7:0];
               2'd1:    din = wr_data[15:8];
               2'd2:    din = wr_data[23:16];
               default: din = wr_data[31:24];
            endcase
            nxt = sel ? ((q_r & ~MASK) | (din & MASK)) : q_r;
         end
         always_ff @(posedge clk) begin
            if (!rst_n) q_r <= RSTV;
            else        q_r <= nxt;
         end
         assign cfg_q[b] = q_r;
         assign cfg_d[b] = nxt;
      end
   end

   always_comb begin
      chg = (cfg_d[OFS_CMD][1:0] != cfg_q[OFS_CMD][1:0]);
      for (int i = OFS_BAR_LO; i < OFS_BAR_END; i++) begin
         if (cfg_d[i] != cfg_q[i]) chg = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) remap_q <= 1'b0;
      else        remap_q <= chg;
   end

   // R10
   remap_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      remap_q |-> $past(wr_en));

   // R5
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(cfg_q));
endmodule

// File: rtl/devcfg_rdmux.sv
module devcfg_rdmux
   import devcfg_pkg::*;
(
   input  cfg_arr_t    cfg,
   input  logic [7:0]  offset,
   input  logic [2:0]  len,
   output logic [31:0] word
);
   logic [7:0] a1, a2, a3;

   always_comb begin
      a1   = offset + 8'd1;
      a2   = offset + 8'd2;
      a3   = offset + 8'd3;
      word = {cfg[a3], cfg[a2], cfg[a1], cfg[offset]};
      if (len == 3'd1)      word[31:8]  = '0;
      else if (len == 3'd2) word[31:16] = '0;
   end
endmodule

// File: rtl/devcfg_space.sv
module devcfg_space
   import devcfg_pkg::*;
#(
   parameter logic [7:0]          BUS_SEL   = 8'h00,
   parameter logic [7:0]          DEVFN_SEL = 8'h18,
   parameter logic [15:0]         VENDOR_ID = 16'hABCD,
   parameter logic [15:0]         DEVICE_ID = 16'h1234,
   parameter bar_size_t           BAR_SIZE  = {32'd0, 32'd0, 32'd0, 32'd0, 32'h100, 32'h1000},
   parameter logic [NUM_BARS-1:0] BAR_IS_IO = 6'b000010,
   parameter logic [31:0]         ROM_SIZE  = 32'h8000
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   input  logic        req_write,
   input  logic [23:0] req_addr,
   input  logic [2:0]  req_len,
   input  logic [31:0] req_wdata,
   output logic        rsp_valid,
   output logic [31:0] rsp_rdata,
   output logic        remap_evt
);
   for (genvar i = 0; i < NUM_BARS; i++) begin : g_chk
      if (BAR_SIZE[i] != 32'd0 && (BAR_SIZE[i] & (BAR_SIZE[i] - 32'd1)) != 32'd0) begin : g_pow2
         $error("base register size must be a power of two");
      end
      if (BAR_SIZE[i] != 32'd0 && BAR_IS_IO[i] && BAR_SIZE[i] < 32'd4) begin : g_iomin
         $error("I/O base register size below 4");
      end
      if (BAR_SIZE[i] != 32'd0 && !BAR_IS_IO[i] && BAR_SIZE[i] < 32'd16) begin : g_memmin
         $error("memory base register size below 16");
      end
   end
   if (ROM_SIZE != 32'd0 && ((ROM_SIZE & (ROM_SIZE - 32'd1)) != 32'd0 || ROM_SIZE < 32'd2))
   begin : g_romchk
      $error("ROM size must be a power of two of at least 2");
   end

   logic       hit, wr_en, rd_en, rd_ok;
   logic [7:0] offset;
   logic [31:0] rd_word;
   cfg_arr_t   cfg_q;

   devcfg_decode #(.BUS_SEL(BUS_SEL), .DEVFN_SEL(DEVFN_SEL)) i_decode (
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_len(req_len), .hit(hit), .offset(offset), .wr_en(wr_en),
      .rd_en(rd_en), .rd_ok(rd_ok)
   );

   devcfg_store #(
      .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .BAR_SIZE(BAR_SIZE),
      .BAR_IS_IO(BAR_IS_IO), .ROM_SIZE(ROM_SIZE)
   ) i_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_off(offset), .wr_len(req_len),
      .wr_data(req_wdata), .cfg_q(cfg_q), .remap_q(remap_evt)
   );

   devcfg_rdmux i_rdmux (.cfg(cfg_q), .offset(offset), .len(req_len), .word(rd_word));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= rd_en;
         if (rd_en) rsp_rdata <= rd_ok ? rd_word : 32'hFFFF_FFFF;
      end
   end

   // R4
   rsp_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write) |=> rsp_valid);

   // R1
   miss_read_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && !hit) |=> (rsp_rdata == 32'hFFFF_FFFF));

   // R3
   badlen_read_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_len != 3'd1 && req_len != 3'd2 && req_len != 3'd4)
      |=> (rsp_rdata == 32'hFFFF_FFFF));
endmodule

// File: tb/test_devcfg_space.sv
module test_devcfg_space;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [23:0] req_addr = '0;
   logic [2:0]  req_len = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid;
   logic [31:0] rsp_rdata;
   logic        remap_evt;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   devcfg_space i_devcfg_space (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .remap_evt(remap_evt)
   );

   // {req[3:0], wr, len[2:0], addr[23:0], wdata[31:0], exp_rdata[31:0], exp_remap}
   localparam int NV = 41;
   localparam logic [96:0] VEC [NV] = '{
      {4'd6,  1'b0, 3'd4, 24'h001800, 32'h0,        32'h1234ABCD, 1'b0}, // R6 identity
      {4'd6,  1'b1, 3'd4, 24'h001800, 32'hFFFFFFFF, 32'h0,        1'b0}, // R6
      {4'd6,  1'b0, 3'd4, 24'h001800, 32'h0,        32'h1234ABCD, 1'b0}, // R6
      {4'd7,  1'b1, 3'd4, 24'h001804, 32'hFFFFFFFF, 32'h0,        1'b1}, // R7 R10
      {4'd7,  1'b0, 3'd4, 24'h001804, 32'h0,        32'h00000007, 1'b0}, // R7
      {4'd9,  1'b1, 3'd4, 24'h001810, 32'hFFFFFFFF, 32'h0,        1'b1}, // R9 R10
      {4'd9,  1'b0, 3'd4, 24'h001810, 32'h0,        32'hFFFFF000, 1'b0}, // R9 memory
      {4'd9,  1'b1, 3'd4, 24'h001814, 32'hFFFFFFFF, 32'h0,        1'b1}, // R9
      {4'd9,  1'b0, 3'd4, 24'h001814, 32'h0,        32'hFFFFFF01, 1'b0}, // R9 I/O
      {4'd9,  1'b1, 3'd4, 24'h001818, 32'hFFFFFFFF, 32'h0,        1'b0}, // R9 size 0
      {4'd9,  1'b0, 3'd4, 24'h001818, 32'h0,        32'h00000000, 1'b0}, // R9
      {4'd9,  1'b1, 3'd4, 24'h001830, 32'hFFFFFFFF, 32'h0,        1'b0}, // R9 ROM
      {4'd9,  1'b0, 3'd4, 24'h001830, 32'h0,        32'hFFFF8001, 1'b0}, // R9
      {4'd8,  1'b1, 3'd1, 24'h00180C, 32'h5A,       32'h0,        1'b0}, // R8
      {4'd8,  1'b0, 3'd1, 24'h00180C, 32'h0,        32'h0000005A, 1'b0}, // R8
      {4'd5,  1'b1, 3'd4, 24'h0018FE, 32'h44332211, 32'h0,        1'b0}, // R5 truncation
      {4'd5,  1'b0, 3'd2, 24'h0018FE, 32'h0,        32'h00002211, 1'b0}, // R5
      {4'd3,  1'b0, 3'd4, 24'h0018FD, 32'h0,        32'hFFFFFFFF, 1'b0}, // R3
      {4'd3,  1'b0, 3'd4, 24'h0018FC, 32'h0,        32'h22110000, 1'b0}, // R3 limit
      {4'd3,  1'b0, 3'd3, 24'h001840, 32'h0,        32'hFFFFFFFF, 1'b0}, // R3 bad len
      {4'd5,  1'b1, 3'd2, 24'h00183C, 32'h0000BEEF, 32'h0,        1'b0}, // R5
      {4'd8,  1'b0, 3'd2, 24'h00183C, 32'h0,        32'h000000EF, 1'b0}, // R8
      {4'd1,  1'b1, 3'd4, 24'h011840, 32'h11223344, 32'h0,        1'b0}, // R1 bus miss
      {4'd1,  1'b0, 3'd4, 24'h001840, 32'h0,        32'h00000000, 1'b0}, // R1
      {4'd1,  1'b0, 3'd4, 24'h011840, 32'h0,        32'hFFFFFFFF, 1'b0}, // R1
      {4'd1,  1'b0, 3'd1, 24'h001940, 32'h0,        32'hFFFFFFFF, 1'b0}, // R1 devfn miss
      {4'd2,  1'b1, 3'd4, 24'h001840, 32'hA1B2C3D4, 32'h0,        1'b0}, // R2
      {4'd2,  1'b0, 3'd1, 24'h001841, 32'h0,        32'h000000C3, 1'b0}, // R2
      {4'd2,  1'b0, 3'd2, 24'h001842, 32'h0,        32'h0000A1B2, 1'b0}, // R2
      {4'd6,  1'b1, 3'd1, 24'h001808, 32'hFF,       32'h0,        1'b0}, // R6
      {4'd6,  1'b0, 3'd1, 24'h001808, 32'h0,        32'h00000000, 1'b0}, // R6
      {4'd10, 1'b1, 3'd4, 24'h001810, 32'hFFFFFFFF, 32'h0,        1'b0}, // R10 same value
      {4'd10, 1'b1, 3'd1, 24'h001804, 32'h03,       32'h0,        1'b0}, // R10 master only
      {4'd7,  1'b0, 3'd1, 24'h001804, 32'h0,        32'h00000003, 1'b0}, // R7
      {4'd10, 1'b1, 3'd1, 24'h001804, 32'h00,       32'h0,        1'b1}, // R10 enables off
      {4'd10, 1'b1, 3'd1, 24'h001844, 32'h55,       32'h0,        1'b0}, // R10 other byte
      {4'd8,  1'b0, 3'd1, 24'h001844, 32'h0,        32'h00000055, 1'b0}, // R8
      {4'd3,  1'b0, 3'd2, 24'h0018FF, 32'h0,        32'hFFFFFFFF, 1'b0}, // R3
      {4'd3,  1'b0, 3'd1, 24'h0018FF, 32'h0,        32'h00000022, 1'b0}, // R3
      {4'd5,  1'b1, 3'd3, 24'h001844, 32'h00FFFFFF, 32'h0,        1'b0}, // R5 bad len
      {4'd5,  1'b0, 3'd1, 24'h001844, 32'h0,        32'h00000055, 1'b0}  // R5
   };

   task automatic check(input bit ok, input int req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL R%0d %s: actual=%08h expected=%08h", req, what, act, exp);
      end
   endtask

   task automatic access(input bit wr, input logic [2:0] len, input logic [23:0] addr,
                         input logic [31:0] data);
      @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_len   = len;
      req_addr  = addr;
      req_wdata = data;
      @(negedge clk);
      req_valid = 1'b0;
      req_write = 1'b0;
   endtask

   task automatic read_chk(input int req, input logic [2:0] len, input logic [23:0] addr,
                           input logic [31:0] exp);
      access(1'b0, len, addr, 32'h0);
      check(rsp_valid === 1'b1, req, "rsp_valid", {31'd0, rsp_valid}, 32'd1);
      check(rsp_rdata === exp, req, "rdata", rsp_rdata, exp);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired: actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      check(rsp_valid === 1'b0, 11, "rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
      check(remap_evt === 1'b0, 11, "remap in reset", {31'd0, remap_evt}, 32'd0);
      rst_n = 1'b1;

      for (int v = 0; v < NV; v++) begin
         logic [96:0] e;
         int          rq;
         e  = VEC[v];
         rq = int'(e[96:93]);
         access(e[92], e[91:89], e[88:65], e[64:33]);
         if (e[92]) begin
            check(rsp_valid === 1'b0, 4, "rsp_valid after write", {31'd0, rsp_valid}, 32'd0);
         end else begin
            check(rsp_valid === 1'b1, 4, "rsp_valid after read", {31'd0, rsp_valid}, 32'd1);
            check(rsp_rdata === e[32:1], rq, $sformatf("vector %0d rdata", v),
                  rsp_rdata, e[32:1]);
         end
         check(remap_evt === e[0], (rq == 10 || e[0]) ? 10 : rq,
               $sformatf("vector %0d remap", v), {31'd0, remap_evt}, {31'd0, e[0]});
         @(negedge clk);
         check(remap_evt === 1'b0, 10, "remap one cycle", {31'd0, remap_evt}, 32'd0);
      end

      // R11 reset restores values after they were changed
      access(1'b1, 3'd4, 24'h001804, 32'h00000007);
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check(rsp_valid === 1'b0, 11, "rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
      check(remap_evt === 1'b0, 11, "remap after reset", {31'd0, remap_evt}, 32'd0);
      rst_n = 1'b1;
      read_chk(11, 3'd4, 24'h001804, 32'h00000000);
      read_chk(11, 3'd1, 24'h00180C, 32'h00000000);
      read_chk(11, 3'd4, 24'h001810, 32'h00000000);
      read_chk(11, 3'd4, 24'h001814, 32'h00000001);
      read_chk(11, 3'd4, 24'h001840, 32'h00000000);
      read_chk(6,  3'd4, 24'h001800, 32'h1234ABCD);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule